// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block predicts which in-flight store a load (or store) should wait for in an out-of-order core. A set map, indexed by instruction PC, assigns PCs that have collided in the past to a common dependence set. A tail table, indexed by set number, records the sequence number of the youngest dispatched store of each set that has not yet issued. The scheduler asks the block, for any PC, which store sequence number to wait for. A result of zero means no dependence.

The predictor learns from ordering violations. When a load has read memory before an older store to the same address, the pair is reported. The two PCs are then joined into one set. If neither PC has a set, a fresh set is created, numbered from the load's map index. If only one PC has a set, the other PC joins it. If both have sets, both PCs end up in the lower-numbered set. Dispatched stores become the tail of their set. A store that issues clears its own tail entry. A pipeline squash drops every tail entry that is younger than the squash point. A global clear forgets everything.

All updates take effect on the next rising clock edge. The lookup is combinational and reads the state as it stands before that edge.

Top module: `dep_predictor`

## Requirements
- R1: The map index of a PC is (PC >> 2) mod MAP_DEPTH. The two low PC bits and all bits above the index are ignored, so PCs that differ only there share a set-map entry.
- R2: After reset, and in the cycle after `clr_i` is high, every set-map entry and every tail entry is invalid. Lookups then return 0, and a store dispatch made after the clear records nothing for a PC whose mapping was cleared. Clear takes precedence over any other update in the same cycle.
- R3: On a violation where neither the load's nor the store's map entry is valid, both entries become valid with set number (load map index mod SET_COUNT).
- R4: On a violation where exactly one of the two entries is valid, the invalid entry takes the valid entry's set number and becomes valid.
- R5: On a violation where both entries are valid, the entry holding the larger set number is rewritten with the smaller one. Equal set numbers are left unchanged.
- R6: A store dispatch (`ins_valid_i` and `ins_is_store_i` high) whose map entry is invalid changes nothing. Otherwise it writes its sequence number into its set's tail entry and marks that entry valid.
- R7: A dispatch with `ins_is_store_i` low changes neither table.
- R8: `look_seq_o` is 0 when the PC's map entry is invalid or its set's tail entry is invalid. Otherwise it is the tail entry's sequence number.
- R9: A store-issue notify invalidates the tail entry of the store's set only if the store's map entry is valid, that tail entry is valid, and it holds exactly the issuing sequence number. Notifies with `iss_is_store_i` low, and notifies with a different sequence number, change nothing.
- R10: A squash invalidates, in one cycle, every tail entry whose sequence number is strictly greater (unsigned) than `sq_seq_i`. Entries equal to or below it are kept.
- R11: If a violation and a store dispatch occur in the same cycle, the dispatch uses the set numbers as they stand after the violation's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Invalidate all map and tail entries |
| viol_valid_i | input | 1 | Ordering violation report |
| viol_store_pc_i | input | PC_W | PC of the store in the violation |
| viol_load_pc_i | input | PC_W | PC of the load in the violation |
| ins_valid_i | input | 1 | Instruction dispatch |
| ins_is_store_i | input | 1 | Dispatched instruction is a store |
| ins_pc_i | input | PC_W | PC of the dispatched instruction |
| ins_seq_i | input | SEQ_W | Sequence number of the dispatched instruction |
| look_pc_i | input | PC_W | PC to look up |
| look_seq_o | output | SEQ_W | Store sequence number to wait for, 0 if none |
| iss_valid_i | input | 1 | Issue notify |
| iss_is_store_i | input | 1 | Issuing instruction is a store |
| iss_pc_i | input | PC_W | PC of the issuing instruction |
| iss_seq_i | input | SEQ_W | Sequence number of the issuing instruction |
| sq_valid_i | input | 1 | Squash |
| sq_seq_i | input | SEQ_W | Squash point; younger tail entries are dropped |

## Verification
A violation report and a store dispatch can arrive in the same cycle. The dispatching store may be the very store the violation is placing into a new set. The bench provokes this with a store PC and a load PC that are both unmapped. It raises the violation and the dispatch of that store on the same edge. It then judges the outcome by looking up the load's PC: the result must be the dispatched sequence number, not zero. This shows that the dispatch saw the map entry the violation had just written.

// File: rtl/dep_pred_pkg.sv
package dep_pred_pkg;

   // Which of the four violation cases applies to a reported pair
   typedef enum logic [1:0] {
      MRG_FRESH    = 2'd0,  // neither side mapped
      MRG_TO_STORE = 2'd1,  // load mapped, store joins it
      MRG_TO_LOAD  = 2'd2,  // store mapped, load joins it
      MRG_LOWEST   = 2'd3   // both mapped, lower set survives
   } merge_kind_e;

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/dep_set_map.sv
module dep_set_map
   import dep_pred_pkg::*;
#(
   parameter int MAP_DEPTH = 64,
   parameter int SET_W     = 4,
   localparam int IDX_W    = $clog2(MAP_DEPTH)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             viol_en_i,
   input  logic [IDX_W-1:0] ld_idx_i,
   input  logic [IDX_W-1:0] st_idx_i,
   input  logic [IDX_W-1:0] ins_idx_i,
   output logic             ins_v_o,
   output logic [SET_W-1:0] ins_id_o,
   input  logic [IDX_W-1:0] look_idx_i,
   output logic             look_v_o,
   output logic [SET_W-1:0] look_id_o,
   input  logic [IDX_W-1:0] iss_idx_i,
   output logic             iss_v_o,
   output logic [SET_W-1:0] iss_id_o
);

   logic             vld_q [MAP_DEPTH];
   logic [SET_W-1:0] id_q  [MAP_DEPTH];

   merge_kind_e      kind;
   logic             ld_v, st_v, ld_we, st_we;
   logic [SET_W-1:0] ld_id, st_id, ld_wid, st_wid;

   assign ld_v  = vld_q[ld_idx_i];
   assign st_v  = vld_q[st_idx_i];
   assign ld_id = id_q[ld_idx_i];
   assign st_id = id_q[st_idx_i];
   assign kind  = merge_kind_e'({st_v, ld_v});

   // Four-way merge decision
   always_comb begin
      ld_we  = 1'b0;
      st_we  = 1'b0;
      ld_wid = st_id;
      st_wid = ld_id;
      unique case (kind)
         MRG_FRESH: begin
            ld_we  = 1'b1;
            st_we  = 1'b1;
            ld_wid = ld_idx_i[SET_W-1:0];
            st_wid = ld_idx_i[SET_W-1:0];
         end
         MRG_TO_STORE: st_we = 1'b1;
         MRG_TO_LOAD:  ld_we = 1'b1;
         default: begin
            if (st_id > ld_id) st_we = 1'b1;
            else               ld_we = 1'b1;
         end
      endcase
   end

   // Dispatch port sees the map as rewritten by a same-cycle violation
   always_comb begin
      ins_v_o  = vld_q[ins_idx_i];
      ins_id_o = id_q[ins_idx_i];
      if (viol_en_i && ld_we && ins_idx_i == ld_idx_i) begin
         ins_v_o  = 1'b1;
         ins_id_o = ld_wid;
      end
      if (viol_en_i && st_we && ins_idx_i == st_idx_i) begin
         ins_v_o  = 1'b1;
         ins_id_o = st_wid;
      end
   end

   assign look_v_o  = vld_q[look_idx_i];
   assign look_id_o = id_q[look_idx_i];
   assign iss_v_o   = vld_q[iss_idx_i];
   assign iss_id_o  = id_q[iss_idx_i];

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clr_i) begin
         for (int i = 0; i < MAP_DEPTH; i++) vld_q[i] <= 1'b0;
      end else if (viol_en_i) begin
         if (ld_we) vld_q[ld_idx_i] <= 1'b1;
         if (st_we) vld_q[st_idx_i] <= 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (viol_en_i && !clr_i) begin
         if (ld_we) id_q[ld_idx_i] <= ld_wid;
         if (st_we) id_q[st_idx_i] <= st_wid;
      end
   end

   // R3: a fresh pair lands in the set named by the load index
   a_r3_fresh_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (viol_en_i && !clr_i && !ld_v && !st_v) |=>
         (vld_q[$past(ld_idx_i)] && vld_q[$past(st_idx_i)] &&
          id_q[$past(st_idx_i)] == $past(ld_idx_i[SET_W-1:0]) &&
          id_q[$past(ld_idx_i)] == $past(ld_idx_i[SET_W-1:0])));

   // R4 / R5: after any violation on a mapped side both PCs agree on one set
   a_r5_pair_joined: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (viol_en_i && !clr_i && (ld_v || st_v)) |=>
         (id_q[$past(ld_idx_i)] == id_q[$past(st_idx_i)]));

   // R5: when both sides are mapped the result is the smaller of the two
   a_r5_lower_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (viol_en_i && !clr_i && ld_v && st_v) |=>
         (id_q[$past(ld_idx_i)] ==
          (($past(ld_id) < $past(st_id)) ? $past(ld_id) : $past(st_id))));

endmodule

// File: rtl/dep_tail_table.sv
module dep_tail_table #(
   parameter int SET_COUNT = 16,
   parameter int SEQ_W     = 16,
   localparam int SET_W    = $clog2(SET_COUNT)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             ins_we_i,
   input  logic [SET_W-1:0] ins_set_i,
   input  logic [SEQ_W-1:0] ins_seq_i,
   input  logic             iss_en_i,
   input  logic [SET_W-1:0] iss_set_i,
   input  logic [SEQ_W-1:0] iss_seq_i,
   input  logic             sq_en_i,
   input  logic [SEQ_W-1:0] sq_seq_i,
   input  logic [SET_W-1:0] look_set_i,
   output logic             look_v_o,
   output logic [SEQ_W-1:0] look_seq_o
);

   logic             vld_q [SET_COUNT];
   logic [SEQ_W-1:0] seq_q [SET_COUNT];

   for (genvar g = 0; g < SET_COUNT; g++) begin : g_ent
      logic hit_ins, kill_iss, kill_sq;

      assign hit_ins  = ins_we_i && ins_set_i == SET_W'(g);
      assign kill_iss = iss_en_i && iss_set_i == SET_W'(g) && seq_q[g] == iss_seq_i;
      assign kill_sq  = sq_en_i && seq_q[g] > sq_seq_i;

      always_ff @(posedge clk_i) begin
         if (!rst_ni || clr_i)            vld_q[g] <= 1'b0;
         else if (hit_ins)                vld_q[g] <= 1'b1;
         else if (kill_iss || kill_sq)    vld_q[g] <= 1'b0;
      end

      always_ff @(posedge clk_i) begin
         if (hit_ins && !clr_i) seq_q[g] <= ins_seq_i;
      end

      // R2: clear empties every tail entry
      a_r2_tail_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
         clr_i |=> !vld_q[g]);

      // R6: a recorded store is visible with its own sequence number
      a_r6_tail_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (ins_we_i && ins_set_i == SET_W'(g) && !clr_i) |=>
            (vld_q[g] && seq_q[g] == $past(ins_seq_i)));

      // R10: younger entries are gone after a squash
      a_r10_squash_young: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (sq_en_i && !(ins_we_i && ins_set_i == SET_W'(g)) && vld_q[g] &&
          seq_q[g] > sq_seq_i) |=> !vld_q[g]);

      // R9: a store issuing with the tail number releases that entry
      a_r9_issue_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (iss_en_i && iss_set_i == SET_W'(g) && vld_q[g] && seq_q[g] == iss_seq_i &&
          !(ins_we_i && ins_set_i == SET_W'(g))) |=> !vld_q[g]);
   end

   assign look_v_o   = vld_q[look_set_i];
   assign look_seq_o = seq_q[look_set_i];

endmodule

// File: rtl/dep_predictor.sv
module dep_predictor
   import dep_pred_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int SEQ_W     = 16,
   parameter int MAP_DEPTH = 64,
   parameter int SET_COUNT = 16,
   parameter int OFS_BITS  = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             viol_valid_i,
   input  logic [PC_W-1:0]  viol_store_pc_i,
   input  logic [PC_W-1:0]  viol_load_pc_i,
   input  logic             ins_valid_i,
   input  logic             ins_is_store_i,
   input  logic [PC_W-1:0]  ins_pc_i,
   input  logic [SEQ_W-1:0] ins_seq_i,
   input  logic [PC_W-1:0]  look_pc_i,
   output logic [SEQ_W-1:0] look_seq_o,
   input  logic             iss_valid_i,
   input  logic             iss_is_store_i,
   input  logic [PC_W-1:0]  iss_pc_i,
   input  logic [SEQ_W-1:0] iss_seq_i,
   input  logic             sq_valid_i,
   input  logic [SEQ_W-1:0] sq_seq_i
);

   localparam int IDX_W = $clog2(MAP_DEPTH);
   localparam int SET_W = $clog2(SET_COUNT);

   if (!is_pow2(MAP_DEPTH)) begin : g_bad_depth
      $error("MAP_DEPTH must be a power of two");
   end
   if (!is_pow2(SET_COUNT) || SET_COUNT < 2 || SET_COUNT > MAP_DEPTH) begin : g_bad_sets
      $error("SET_COUNT must be a power of two in 2..MAP_DEPTH");
   end
   if (PC_W < OFS_BITS + IDX_W) begin : g_bad_pc
      $error("PC_W too narrow for OFS_BITS + index");
   end

   logic [IDX_W-1:0] ld_idx, st_idx, ins_idx, look_idx, iss_idx;
   assign ld_idx   = viol_load_pc_i [OFS_BITS +: IDX_W];
   assign st_idx   = viol_store_pc_i[OFS_BITS +: IDX_W];
   assign ins_idx  = ins_pc_i       [OFS_BITS +: IDX_W];
   assign look_idx = look_pc_i      [OFS_BITS +: IDX_W];
   assign iss_idx  = iss_pc_i       [OFS_BITS +: IDX_W];

   logic             ins_map_v, look_map_v, iss_map_v, tail_v;
   logic [SET_W-1:0] ins_set, look_set, iss_set;
   logic [SEQ_W-1:0] tail_seq;

   dep_set_map #(
      .MAP_DEPTH (MAP_DEPTH),
      .SET_W     (SET_W)
   ) u_map (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clr_i),
      .viol_en_i  (viol_valid_i),
      .ld_idx_i   (ld_idx),
      .st_idx_i   (st_idx),
      .ins_idx_i  (ins_idx),
      .ins_v_o    (ins_map_v),
      .ins_id_o   (ins_set),
      .look_idx_i (look_idx),
      .look_v_o   (look_map_v),
      .look_id_o  (look_set),
      .iss_idx_i  (iss_idx),
      .iss_v_o    (iss_map_v),
      .iss_id_o   (iss_set)
   );

   dep_tail_table #(
      .SET_COUNT (SET_COUNT),
      .SEQ_W     (SEQ_W)
   ) u_tail (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clr_i),
      .ins_we_i   (ins_valid_i && ins_is_store_i && ins_map_v),
      .ins_set_i  (ins_set),
      .ins_seq_i  (ins_seq_i),
      .iss_en_i   (iss_valid_i && iss_is_store_i && iss_map_v),
      .iss_set_i  (iss_set),
      .iss_seq_i  (iss_seq_i),
      .sq_en_i    (sq_valid_i),
      .sq_seq_i   (sq_seq_i),
      .look_set_i (look_set),
      .look_v_o   (tail_v),
      .look_seq_o (tail_seq)
   );

   assign look_seq_o = (look_map_v && tail_v) ? tail_seq : '0;

   // R2: the cycle after a clear, every lookup reports no dependence
   a_r2_clear_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> look_seq_o == '0);

endmodule

// File: tb/dep_predictor_bench.sv
module dep_predictor_bench;
   localparam int CLK_PERIOD = 10;
   localparam int PC_W  = 32;
   localparam int SEQ_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clr = 1'b0;
   logic             viol_v = 1'b0;
   logic [PC_W-1:0]  viol_st = '0, viol_ld = '0;
   logic             ins_v = 1'b0, ins_st = 1'b0;
   logic [PC_W-1:0]  ins_pc = '0;
   logic [SEQ_W-1:0] ins_seq = '0;
   logic [PC_W-1:0]  look_pc = '0;
   logic [SEQ_W-1:0] look_seq;
   logic             iss_v = 1'b0, iss_st = 1'b0;
   logic [PC_W-1:0]  iss_pc = '0;
   logic [SEQ_W-1:0] iss_seq = '0;
   logic             sq_v = 1'b0;
   logic [SEQ_W-1:0] sq_seq = '0;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dep_predictor u_dep_predictor (
      .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
      .viol_valid_i(viol_v), .viol_store_pc_i(viol_st), .viol_load_pc_i(viol_ld),
      .ins_valid_i(ins_v), .ins_is_store_i(ins_st), .ins_pc_i(ins_pc), .ins_seq_i(ins_seq),
      .look_pc_i(look_pc), .look_seq_o(look_seq),
      .iss_valid_i(iss_v), .iss_is_store_i(iss_st), .iss_pc_i(iss_pc), .iss_seq_i(iss_seq),
      .sq_valid_i(sq_v), .sq_seq_i(sq_seq)
   );

   // PCs used below (index = PC>>2 mod 64, new set = index mod 16)
   localparam logic [PC_W-1:0] S1 = 32'h040;  // idx 16
   localparam logic [PC_W-1:0] L1 = 32'h088;  // idx 34 -> set 2
   localparam logic [PC_W-1:0] S2 = 32'h0C0;  // idx 48
   localparam logic [PC_W-1:0] L2 = 32'h0D0;  // idx 52
   localparam logic [PC_W-1:0] S3 = 32'h014;  // idx 5
   localparam logic [PC_W-1:0] L3 = 32'h01C;  // idx 7 -> set 7
   localparam logic [PC_W-1:0] S4 = 32'h400;  // idx 0
   localparam logic [PC_W-1:0] L4 = 32'h410;  // idx 4 -> set 4
   localparam logic [PC_W-1:0] S5 = 32'h624;  // idx 9
   localparam logic [PC_W-1:0] L5 = 32'h62C;  // idx 11 -> set 11

   task automatic quiet();
      clr = 0; viol_v = 0; ins_v = 0; ins_st = 0; iss_v = 0; iss_st = 0; sq_v = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      quiet();
   endtask

   task automatic expect_look(input string req, input logic [PC_W-1:0] pc,
                              input logic [SEQ_W-1:0] exp);
      look_pc = pc;
      #1;
      checks++;
      if (look_seq !== exp) begin
         failures++;
         $display("FAIL %s: lookup pc=%h got %0d expected %0d", req, pc, look_seq, exp);
      end
   endtask

   task automatic do_viol(input logic [PC_W-1:0] st, input logic [PC_W-1:0] ld);
      viol_v = 1; viol_st = st; viol_ld = ld;
      tick();
   endtask

   task automatic do_ins(input logic is_st, input logic [PC_W-1:0] pc,
                         input logic [SEQ_W-1:0] sq);
      ins_v = 1; ins_st = is_st; ins_pc = pc; ins_seq = sq;
      tick();
   endtask

   task automatic do_iss(input logic is_st, input logic [PC_W-1:0] pc,
                         input logic [SEQ_W-1:0] sq);
      iss_v = 1; iss_st = is_st; iss_pc = pc; iss_seq = sq;
      tick();
   endtask

   task automatic do_squash(input logic [SEQ_W-1:0] sq);
      sq_v = 1; sq_seq = sq;
      tick();
   endtask

   task automatic t_reset();
      expect_look("R2", L1, 0);
      expect_look("R8", S1, 0);
   endtask

   task automatic t_fresh_set();
      do_viol(S1, L1);
      do_ins(1, S1, 5);
      expect_look("R3", L1, 5);
      expect_look("R3", S1, 5);
      expect_look("R1", L1 + 32'h100, 5);  // same index, higher bits differ
      expect_look("R1", L1 + 32'h2, 5);    // low offset bits ignored
      expect_look("R8", L2, 0);            // unmapped PC
   endtask

   task automatic t_load_and_unmapped_insert();
      do_ins(0, L1, 9);
      expect_look("R7", L1, 5);
      do_ins(1, 32'h300, 7);               // idx 0, not mapped
      expect_look("R6", 32'h300, 0);
      expect_look("R6", L1, 5);
   endtask

   task automatic t_join();
      do_viol(S2, L1);                     // load mapped, store joins set 2
      do_ins(1, S2, 11);
      expect_look("R4", L1, 11);
      do_viol(S1, L2);                     // store mapped, load joins set 2
      expect_look("R4", L2, 11);
   endtask

   task automatic t_lower_wins();
      do_viol(S3, L3);                     // new set 7
      do_ins(1, S3, 20);
      expect_look("R3", L3, 20);
      do_viol(S3, L1);                     // store has 7, load 2 -> store to 2
      do_ins(1, S3, 21);
      expect_look("R5", L1, 21);
      expect_look("R5", L3, 20);           // load L3 still in set 7
      do_viol(S2, L3);                     // load has 7, store 2 -> load to 2
      expect_look("R5", L3, 21);
   endtask

   task automatic t_issue();
      do_iss(1, S3, 20);                   // different sequence number
      expect_look("R9", L1, 21);
      do_iss(0, S3, 21);                   // not a store
      expect_look("R9", L1, 21);
      do_iss(1, S3, 21);
      expect_look("R9", L1, 0);
   endtask

   task automatic t_squash();
      do_ins(1, S1, 30);
      do_viol(S4, L4);                     // new set 4
      do_ins(1, S4, 40);
      expect_look("R10", L4, 40);
      do_squash(35);
      expect_look("R10", L1, 30);
      expect_look("R10", L4, 0);
      do_ins(1, S4, 50);
      do_squash(50);                       // equal is kept
      expect_look("R10", L4, 50);
      do_squash(49);
      expect_look("R10", L4, 0);
   endtask

   task automatic t_same_cycle();
      viol_v = 1; viol_st = S5; viol_ld = L5;
      ins_v = 1; ins_st = 1; ins_pc = S5; ins_seq = 60;
      tick();
      expect_look("R11", L5, 60);
   endtask

   task automatic t_clear();
      clr = 1; ins_v = 1; ins_st = 1; ins_pc = S1; ins_seq = 65;
      tick();
      expect_look("R2", L1, 0);
      expect_look("R2", L5, 0);
      do_ins(1, S1, 70);
      expect_look("R2", L1, 0);
   endtask

   initial begin
      quiet();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_fresh_set();
      t_load_and_unmapped_insert();
      t_join();
      t_lower_wins();
      t_issue();
      t_squash();
      t_same_cycle();
      t_clear();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule